// File: doc/BRIEF.md
# Debug-Mode Reset State Controller

This block turns three board-level pins into the internal reset controls of a processor core and its debug port. The pins are a mode pin (high selects normal mode, low selects emulator mode), an active-low system reset and an active-low debug-port reset. The block drives three controls. The first is an active-low CPU power-on reset. The second is an active-low reset for the debug interface. The third is a CPU run enable that tells the core it may fetch.

In emulator mode the block also keeps a sticky hold flag. Whenever the debug-port reset is seen low in that mode, the flag is set. While it is set, the debug interface can come out of reset but the CPU is kept from starting. Only a power-on reset clears the flag, and a power-on reset here means system reset low with the debug-port reset high. This lets an attached debugger take control before any code runs.

All pins pass through two-flop synchronisers on the system clock. Both reset outputs are asserted asynchronously and released on a clock edge. The mode pin is captured only while the system reset is active.

Top module: `rst_mode_ctl`

## Requirements
- R1: In normal mode (mode_i = 1), with both reset pins low, cpu_por_no = 0, dbg_rst_no = 0 and cpu_run_o = 0.
- R2: In normal mode, sys_rst_ni = 0 with dbg_rst_ni = 1 gives only the power-on reset. sys_rst_ni = 1 with dbg_rst_ni = 0 gives only the debug reset, and cpu_run_o stays 1. Both pins high gives no reset and cpu_run_o = 1.
- R3: In emulator mode (mode_i = 0), dbg_rst_ni = 0 sets hold_o = 1 and forces cpu_run_o = 0, whether sys_rst_ni is high or low.
- R4: While hold_o = 1 and sys_rst_ni = 1, raising dbg_rst_ni releases dbg_rst_no to 1, but cpu_run_o stays 0 and hold_o stays 1.
- R5: sys_rst_ni = 0 with dbg_rst_ni = 1 clears hold_o to 0. After both pins are high again, cpu_run_o returns to 1.
- R6: hold_o cannot be cleared by any other pin combination. This includes both pins low.
- R7: A low level on either reset pin drives the matching reset output low without waiting for a clock edge. After the pin rises, the output stays low after the first rising clock edge and goes high after the second.
- R8: The mode is captured only while the synchronised system reset is low. A change of mode_i while sys_rst_ni is high has no effect on decoding.
- R9: In emulator mode with hold_o = 0, the combinations sys low/debug high and both high map as in normal mode: power-on reset only, and run respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| mode_i | input | 1 | Mode pin: 1 normal, 0 emulator |
| sys_rst_ni | input | 1 | System reset pin, active low |
| dbg_rst_ni | input | 1 | Debug-port reset pin, active low |
| cpu_por_no | output | 1 | CPU power-on reset, active low |
| dbg_rst_no | output | 1 | Debug-interface reset, active low |
| cpu_run_o | output | 1 | CPU start enable |
| hold_o | output | 1 | Sticky reset-hold flag |

## Verification
The assertions assume that mode_i changes only while sys_rst_ni is low. They also assume the pin stays stable for at least three clock cycles before the system reset is released, so that the captured mode is settled before decoding starts. The hold-flag properties are disabled while the captured mode or the flag is still unknown, which is the case before the first power-on reset. The stimulus table changes the mode only in rows that also hold the system reset low, and it holds each row for six cycles. The one mode change made while running comes in a directed test whose purpose is to show that such a change is ignored.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_POR  = 3'd1,
    ST_DBG  = 3'd2,
    ST_BOTH = 3'd3,
    ST_HOLD = 3'd4
  } chip_state_e;

  // Map synchronised pin levels and hold flag onto one chip state.
  function automatic chip_state_e decode_state(logic emu, logic sys_up,
                                               logic dbg_up, logic hold);
    if (!sys_up) begin
      if (dbg_up)   return ST_POR;
      else if (emu) return ST_HOLD;
      else          return ST_BOTH;
    end
    if (hold || (emu && !dbg_up)) return ST_HOLD;
    return dbg_up ? ST_RUN : ST_DBG;
  endfunction

  function automatic logic run_allowed(chip_state_e st);
    return (st == ST_RUN) || (st == ST_DBG);
  endfunction

  // Condition that clears the hold flag.
  function automatic logic is_por_only(logic sys_up, logic dbg_up);
    return !sys_up && dbg_up;
  endfunction

endpackage

// File: rtl/rmc_rst_sync.sv
module rmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= 1'b1;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign rst_no = chain_q[STAGES-1];

  // Release only follows a pin that was already high at the previous edge.
  assert_release_sync_R7: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $rose(rst_no) |-> $past(arst_ni));

endmodule

// File: rtl/rmc_bit_sync.sv
module rmc_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i) chain_q[i] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i) chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rmc_hold_ctl.sv
module rmc_hold_ctl
  import rmc_pkg::*;
(
  input  logic clk_i,
  input  logic sys_up_i,
  input  logic dbg_up_i,
  input  logic mode_s_i,
  output logic emu_o,
  output logic hold_o
);
  logic mode_q;
  logic hold_q;
  logic por_only;
  logic hold_set;

  // Mode is captured only while the system reset is active.
  always_ff @(posedge clk_i) begin
    if (!sys_up_i) mode_q <= mode_s_i;
  end

  assign emu_o    = !mode_q;
  assign por_only = is_por_only(sys_up_i, dbg_up_i);
  assign hold_set = emu_o && !dbg_up_i;

  always_ff @(posedge clk_i) begin
    if (por_only)      hold_q <= 1'b0;
    else if (hold_set) hold_q <= 1'b1;
  end

  assign hold_o = hold_q;

  assert_hold_clear_R5: assert property (@(posedge clk_i)
    disable iff ($isunknown({mode_q, hold_q}))
    por_only |=> !hold_q);

  assert_hold_enter_R3: assert property (@(posedge clk_i)
    disable iff ($isunknown({mode_q, hold_q}))
    (emu_o && !dbg_up_i) |=> hold_q);

  assert_hold_sticky_R6: assert property (@(posedge clk_i)
    disable iff ($isunknown({mode_q, hold_q}))
    (hold_q && !por_only) |=> hold_q);

  assert_mode_frozen_R8: assert property (@(posedge clk_i)
    disable iff ($isunknown({mode_q, hold_q}))
    $past(sys_up_i) |-> $stable(mode_q));

endmodule

// File: rtl/rst_mode_ctl.sv
module rst_mode_ctl
  import rmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic mode_i,
  input  logic sys_rst_ni,
  input  logic dbg_rst_ni,
  output logic cpu_por_no,
  output logic dbg_rst_no,
  output logic cpu_run_o,
  output logic hold_o
);
  logic        sys_up;
  logic        dbg_up;
  logic        mode_s;
  logic        emu;
  logic        hold;
  chip_state_e state;

  rmc_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (
    .clk_i  (clk_i),
    .arst_ni(sys_rst_ni),
    .rst_no (sys_up)
  );

  rmc_rst_sync #(.STAGES(SYNC_STAGES)) u_dbg_sync (
    .clk_i  (clk_i),
    .arst_ni(dbg_rst_ni),
    .rst_no (dbg_up)
  );

  rmc_bit_sync #(.STAGES(SYNC_STAGES)) u_mode_sync (
    .clk_i(clk_i),
    .d_i  (mode_i),
    .q_o  (mode_s)
  );

  rmc_hold_ctl u_hold (
    .clk_i   (clk_i),
    .sys_up_i(sys_up),
    .dbg_up_i(dbg_up),
    .mode_s_i(mode_s),
    .emu_o   (emu),
    .hold_o  (hold)
  );

  assign state      = decode_state(emu, sys_up, dbg_up, hold);
  assign cpu_por_no = sys_up;
  assign dbg_rst_no = dbg_up;
  assign cpu_run_o  = run_allowed(state);
  assign hold_o     = hold;

  // A debug-only reset in normal mode must leave the CPU running.
  assert_dbg_only_runs_R2: assert property (@(posedge clk_i)
    disable iff ($isunknown({emu, hold}))
    (!emu && !hold && sys_up && !dbg_up) |-> cpu_run_o);

endmodule

// File: tb/rst_mode_ctl_test.sv
module rst_mode_ctl_test;
  logic clk = 1'b0;
  logic mode_i = 1'b1;
  logic sys_rst_ni = 1'b1;
  logic dbg_rst_ni = 1'b1;
  logic cpu_por_no, dbg_rst_no, cpu_run_o, hold_o;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  rst_mode_ctl uut (
    .clk_i     (clk),
    .mode_i    (mode_i),
    .sys_rst_ni(sys_rst_ni),
    .dbg_rst_ni(dbg_rst_ni),
    .cpu_por_no(cpu_por_no),
    .dbg_rst_no(dbg_rst_no),
    .cpu_run_o (cpu_run_o),
    .hold_o    (hold_o)
  );

  // Row: {mode, sys, dbg, exp_por_n, exp_dbg_n, exp_run, exp_hold}
  localparam int NROW = 20;
  localparam logic [6:0] VEC [NROW] = '{
    7'b101_0100, // R2 por only
    7'b111_1110, // R2 run
    7'b110_1010, // R2 debug only
    7'b100_0000, // R1 both low
    7'b111_1110, // R2 run
    7'b001_0100, // R9 enter emulator through por
    7'b011_1110, // R9 emulator run
    7'b010_1001, // R3 hold with sys high
    7'b011_1101, // R4 debug released, cpu blocked
    7'b000_0001, // R6 both low keeps hold
    7'b010_1001, // R6
    7'b011_1101, // R4
    7'b001_0100, // R5 por clears hold
    7'b011_1110, // R5 run again
    7'b000_0001, // R3 hold with sys low
    7'b010_1001, // R3
    7'b011_1101, // R4
    7'b001_0100, // R5
    7'b101_0100, // R2 back to normal
    7'b111_1110  // R2 run
  };

  function automatic string tag_of(int i);
    case (i)
      3:                return "R1";
      5, 6:             return "R9";
      7, 14, 15:        return "R3";
      8, 11, 16:        return "R4";
      9, 10:            return "R6";
      12, 13, 17:       return "R5";
      default:          return "R2";
    endcase
  endfunction

  task automatic check(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {cpu_por_no, dbg_rst_no, cpu_run_o, hold_o};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {por_n,dbg_n,run,hold} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #1 sys_rst_ni = 1'b0; dbg_rst_ni = 1'b0;
    #1 dbg_rst_ni = 1'b1;
    check_bit("R7", cpu_por_no, 1'b0);
    repeat (6) @(negedge clk);
    check("R5", 4'b0100); // reset state: por only, hold clear

    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      {mode_i, sys_rst_ni, dbg_rst_ni} = VEC[i][6:4];
      repeat (6) @(negedge clk);
      check(tag_of(i), VEC[i][3:0]);
    end

    // R8: mode change while running is ignored
    mode_i = 1'b0;
    repeat (6) @(negedge clk);
    dbg_rst_ni = 1'b0;
    repeat (6) @(negedge clk);
    check("R8", 4'b1010);
    dbg_rst_ni = 1'b1;
    repeat (6) @(negedge clk);
    check("R8", 4'b1110);
    mode_i = 1'b1;
    repeat (6) @(negedge clk);

    // R7: asynchronous assertion and two-edge release, system reset
    #3 sys_rst_ni = 1'b0;
    #2 check_bit("R7", cpu_por_no, 1'b0);
    @(negedge clk) sys_rst_ni = 1'b1;
    @(negedge clk) check_bit("R7", cpu_por_no, 1'b0);
    @(negedge clk) check_bit("R7", cpu_por_no, 1'b1);

    // R7: same for debug reset
    #3 dbg_rst_ni = 1'b0;
    #2 check_bit("R7", dbg_rst_no, 1'b0);
    @(negedge clk) dbg_rst_ni = 1'b1;
    @(negedge clk) check_bit("R7", dbg_rst_no, 1'b0);
    @(negedge clk) check_bit("R7", dbg_rst_no, 1'b1);
    check_bit("R2", cpu_run_o, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule